// File: doc/BRIEF.md
# Rectangular pattern fill engine

The engine takes one fill command and paints a constant pattern over a rectangle of pixels held in byte-addressed memory. A command gives a start address, a signed row pitch in bytes, a packed size word, a 32-bit pattern, an 8-bit raster-operation code, a colour-depth code and a two-bit channel mask. The engine emits one memory write beat per pixel on a 32-bit single-beat write port with per-byte enables. Each beat is held until the memory accepts it.

The pixels of a row go out in ascending address order. Each next row starts one pitch further on from the start of the previous row, and the pitch may be zero or negative. Before any beat goes out, the command is checked against the alignment and size rules and the raster-operation code is examined. A command that fails these checks, or that leaves nothing to write, finishes without touching memory. Every accepted command ends with exactly one `done` pulse.

Top module: `rect_fill`

## Requirements
- R1: Pixel size follows `cmd_depth`: code 0 is 1 byte, code 1 is 2 bytes (565), code 2 is 4 bytes (8888). Within a row, consecutive beats step the address by the pixel size, starting at the row start. Row r starts at base + r*pitch, and the pitch is a signed 16-bit byte count.
- R2: For code 0, a beat enables the single byte lane given by address bits 1:0, and the data is the pattern's low byte repeated in all four lanes. For code 1, it enables lanes {a+1,a} with a = address bits 1:0, and the data is the pattern's low half repeated twice.
- R3: For code 2, the data is the whole pattern. `cmd_wmask` bit 0 enables lanes 2:0 (colour) and bit 1 enables lane 3 (alpha), independently of each other.
- R4: While `mem_we` is high and `mem_ready` is low, the beat's address, enables and data stay unchanged on the next cycle.
- R5: `done` is high for exactly one cycle, in the cycle after the edge that accepts the last beat. `busy` is high from acceptance until then, and `mem_we` is never high outside `busy`.
- R6: `err_param` is set, and nothing is written, when any of these holds: depth code 3, a base address that is not a multiple of the pixel size, a pitch that is not a multiple of 4, a width of 32768 or more, or a width that is not a multiple of the pixel size.
- R7: Raster code 0xF0 fills with the pattern. Code 0xAA finishes with `done` and no beats. Any other code sets `err_rop` and writes nothing. The error flags appear with `done` and clear at the next accepted command.
- R8: A zero width, a zero height, or code 2 with both mask bits clear finishes with `done` and no beats.
- R9: A pitch of zero with a height of 1 is a valid single-row fill.
- R10: `cmd_size` carries the height in bits 31:16 and the width in bytes in bits 15:0.
- R11: After reset, `busy`, `done`, `mem_we`, `err_param` and `err_rop` are low.
- R12: A command is accepted on a clock edge where `cmd_start` is high and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start a command (taken when idle) |
| cmd_base | input | 32 | Destination start byte address |
| cmd_pitch | input | 16 | Signed row pitch in bytes |
| cmd_size | input | 32 | Height in 31:16, width in bytes in 15:0 |
| cmd_pattern | input | 32 | Fill pattern |
| cmd_rop | input | 8 | Raster-operation code |
| cmd_depth | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit |
| cmd_wmask | input | 2 | Bit 0 colour, bit 1 alpha (32-bit only) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_param | output | 1 | Alignment or size rule broken |
| err_rop | output | 1 | Unsupported raster code |
| mem_we | output | 1 | Write beat valid |
| mem_addr | output | 32 | Byte address of the pixel |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the beat |

## Verification
The rectangles are driven at each depth, at unaligned byte and half-word start lanes, and with positive, negative and zero pitches. These tell apart lane selection by address, stepping by pixel size, and row stepping by pitch rather than by width. The 32-bit cases separate colour-only, alpha-only and full masks. `mem_ready` follows a pseudo-random pattern, so every beat is also checked under stalls. The rejected and empty commands each break one rule at a time: alignment, pitch, width limit, width granularity, bad depth, raster code, zero height and empty mask. Each of these must finish with `done` and without a single beat.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    DEPTH_8   = 2'd0,
    DEPTH_16  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_BAD = 2'd3
  } depth_e;

  localparam logic [7:0] ROP_FILL = 8'hF0;
  localparam logic [7:0] ROP_KEEP = 8'hAA;
  localparam int         DW       = 32;
  localparam int         BW       = DW / 8;

  function automatic logic [2:0] pix_bytes(depth_e d);
    case (d)
      DEPTH_8:  return 3'd1;
      DEPTH_16: return 3'd2;
      default:  return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] align_mask(depth_e d);
    case (d)
      DEPTH_8:  return 2'b00;
      DEPTH_16: return 2'b01;
      default:  return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/rf_check.sv
module rf_check
  import rf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int WW      = 16,
  parameter int HW      = 16,
  parameter int W_LIMIT = 32768
) (
  input  logic [AW-1:0] base,
  input  logic [PW-1:0] pitch,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] height,
  input  logic [7:0]    rop,
  input  depth_e        depth,
  input  logic [1:0]    wmask,
  output logic          bad_param,
  output logic          bad_rop,
  output logic          no_work
);
  logic [1:0] amask;

  always_comb begin
    amask     = align_mask(depth);
    bad_param = (depth == DEPTH_BAD)
              || ((base[1:0] & amask) != 2'b00)
              || (pitch[1:0] != 2'b00)
              || (32'(width) >= 32'(W_LIMIT))
              || ((width[1:0] & amask) != 2'b00);
    bad_rop   = (rop != ROP_FILL) && (rop != ROP_KEEP);
    no_work   = (width == '0) || (height == '0) || (rop == ROP_KEEP)
              || ((depth == DEPTH_32) && (wmask == 2'b00));
  end
endmodule

// File: rtl/rf_lane.sv
module rf_lane
  import rf_pkg::*;
(
  input  logic [1:0]    addr_lo,
  input  depth_e        depth,
  input  logic [1:0]    wmask,
  input  logic [DW-1:0] pattern,
  output logic [BW-1:0] be,
  output logic [DW-1:0] data
);
  always_comb begin
    case (depth)
      DEPTH_8: begin
        be   = 4'b0001 << addr_lo;
        data = {4{pattern[7:0]}};
      end
      DEPTH_16: begin
        be   = 4'b0011 << addr_lo;
        data = {2{pattern[15:0]}};
      end
      default: begin
        be   = {wmask[1], {3{wmask[0]}}};
        data = pattern;
      end
    endcase
  end
endmodule

// File: rtl/rf_walker.sv
module rf_walker #(
  parameter int AW = 32,
  parameter int WW = 16,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] pitch,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] height,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt_addr,
  output logic          last
);
  logic [AW-1:0] row_base, pitch_q;
  logic [WW-1:0] col, width_q;
  logic [HW-1:0] row, height_q;
  logic [2:0]    step_q;
  logic          wrap;

  always_comb begin
    wrap = (col + WW'(step_q)) == width_q;
    last = wrap && (row == height_q - HW'(1));
    if (load)
      nxt_addr = base;
    else if (adv)
      nxt_addr = wrap ? row_base + pitch_q : addr + AW'(step_q);
    else
      nxt_addr = addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_base <= '0;
      addr     <= '0;
      pitch_q  <= '0;
      col      <= '0;
      width_q  <= '0;
      row      <= '0;
      height_q <= '0;
      step_q   <= '0;
    end else if (load) begin
      row_base <= base;
      addr     <= base;
      pitch_q  <= pitch;
      col      <= '0;
      width_q  <= width;
      row      <= '0;
      height_q <= height;
      step_q   <= step;
    end else if (adv) begin
      addr <= nxt_addr;
      if (wrap) begin
        row_base <= nxt_addr;
        col      <= '0;
        row      <= row + HW'(1);
      end else begin
        col <= col + WW'(step_q);
      end
    end
  end
endmodule

// File: rtl/rect_fill.sv
module rect_fill
  import rf_pkg::*;
#(
  parameter int AW      = 32,
  parameter int PW      = 16,
  parameter int W_LIMIT = 32768
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_base,
  input  logic [PW-1:0] cmd_pitch,
  input  logic [31:0]   cmd_size,
  input  logic [31:0]   cmd_pattern,
  input  logic [7:0]    cmd_rop,
  input  logic [1:0]    cmd_depth,
  input  logic [1:0]    cmd_wmask,
  output logic          busy,
  output logic          done,
  output logic          err_param,
  output logic          err_rop,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready
);
  localparam int WW = 16;
  localparam int HW = 16;

  depth_e        depth_in, depth_q, depth_sel;
  logic [1:0]    wmask_q, wmask_sel;
  logic [WW-1:0] width_in;
  logic [HW-1:0] height_in;
  logic [AW-1:0] pitch_ext, nxt_addr;
  logic          bad_param, bad_rop, no_work;
  logic          accept, go, fire, last;
  logic [BW-1:0] lane_be;
  logic [DW-1:0] lane_data;

  assign depth_in  = depth_e'(cmd_depth);
  assign width_in  = cmd_size[WW-1:0];
  assign height_in = cmd_size[31:32-HW];
  assign pitch_ext = {{(AW-PW){cmd_pitch[PW-1]}}, cmd_pitch};
  assign accept    = cmd_start && !busy;
  assign go        = accept && !bad_param && !bad_rop && !no_work;
  assign fire      = mem_we && mem_ready;
  assign depth_sel = go ? depth_in : depth_q;
  assign wmask_sel = go ? cmd_wmask : wmask_q;

  rf_check #(.AW(AW), .PW(PW), .WW(WW), .HW(HW), .W_LIMIT(W_LIMIT)) u_check (
    .base(cmd_base), .pitch(cmd_pitch), .width(width_in), .height(height_in),
    .rop(cmd_rop), .depth(depth_in), .wmask(cmd_wmask),
    .bad_param(bad_param), .bad_rop(bad_rop), .no_work(no_work)
  );

  rf_walker #(.AW(AW), .WW(WW), .HW(HW)) u_walk (
    .clk(clk), .rst(rst), .load(go), .adv(fire && !last),
    .base(cmd_base), .pitch(pitch_ext), .width(width_in), .height(height_in),
    .step(pix_bytes(depth_in)), .addr(mem_addr), .nxt_addr(nxt_addr), .last(last)
  );

  rf_lane u_lane (
    .addr_lo(nxt_addr[1:0]), .depth(depth_sel), .wmask(wmask_sel),
    .pattern(cmd_pattern), .be(lane_be), .data(lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      err_param <= 1'b0;
      err_rop   <= 1'b0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      depth_q   <= DEPTH_8;
      wmask_q   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        err_param <= bad_param;
        err_rop   <= bad_rop;
        if (go) begin
          busy      <= 1'b1;
          mem_we    <= 1'b1;
          mem_be    <= lane_be;
          mem_wdata <= lane_data;
          depth_q   <= depth_in;
          wmask_q   <= cmd_wmask;
        end else begin
          done <= 1'b1;
        end
      end else if (fire) begin
        if (last) begin
          mem_we <= 1'b0;
          busy   <= 1'b0;
          done   <= 1'b1;
        end else begin
          mem_be <= lane_be;
        end
      end
    end
  end
endmodule

// File: rtl/rect_fill_chk.sv
module rect_fill_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        err_param,
  input logic        err_rop,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_ready
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_we));

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy)) |-> done);

  // R6
  err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (err_param || err_rop) |-> !mem_we);

  // R2
  beat_has_lane_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_be != 4'b0000));
endmodule

bind rect_fill rect_fill_chk u_rect_fill_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .err_param(err_param),
  .err_rop(err_rop), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/test_rect_fill.sv
module test_rect_fill;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_start = 1'b0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_pitch = '0;
  logic [31:0] cmd_size = '0;
  logic [31:0] cmd_pattern = '0;
  logic [7:0]  cmd_rop = '0;
  logic [1:0]  cmd_depth = '0;
  logic [1:0]  cmd_wmask = '0;
  logic        busy, done, err_param, err_rop, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [31:0] q_addr[$];
  logic [3:0]  q_be[$];
  logic [31:0] q_dat[$];

  always #2 clk = ~clk;

  rect_fill i_rect_fill (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_base(cmd_base),
    .cmd_pitch(cmd_pitch), .cmd_size(cmd_size), .cmd_pattern(cmd_pattern),
    .cmd_rop(cmd_rop), .cmd_depth(cmd_depth), .cmd_wmask(cmd_wmask),
    .busy(busy), .done(done), .err_param(err_param), .err_rop(err_rop),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] base, input int pitch, input int w, input int h,
                     input logic [31:0] pat, input logic [7:0] rop, input int depth,
                     input logic [1:0] wm, input string req);
    int  cpp;
    int  amask;
    bit  e_par, e_rop, work;
    cpp   = (depth == 0) ? 1 : (depth == 1) ? 2 : 4;
    amask = cpp - 1;
    e_par = (depth == 3) || ((base & amask) != 0) || ((pitch & 3) != 0)
         || (w >= 32768) || ((w & amask) != 0);
    e_rop = (rop != 8'hF0) && (rop != 8'hAA);
    work  = !e_par && !e_rop && rop == 8'hF0 && w != 0 && h != 0
         && !(depth == 2 && wm == 2'b00);
    if (work) begin
      for (int r = 0; r < h; r++) begin
        for (int c = 0; c < w; c += cpp) begin
          logic [31:0] a;
          a = base + 32'(r * pitch) + 32'(c);
          q_addr.push_back(a);
          if (depth == 0) begin
            q_be.push_back(4'b0001 << a[1:0]);
            q_dat.push_back({4{pat[7:0]}});
          end else if (depth == 1) begin
            q_be.push_back(4'b0011 << a[1:0]);
            q_dat.push_back({2{pat[15:0]}});
          end else begin
            q_be.push_back({wm[1], {3{wm[0]}}});
            q_dat.push_back(pat);
          end
        end
      end
    end
    @(negedge clk);
    cmd_base = base; cmd_pitch = 16'(pitch); cmd_size = {16'(h), 16'(w)};
    cmd_pattern = pat; cmd_rop = rop; cmd_depth = 2'(depth); cmd_wmask = wm;
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (q_addr.size() > 0) begin
      chk(mem_we && busy && !done && mem_addr == q_addr[0] && mem_be == q_be[0]
          && mem_wdata == q_dat[0], req, "beat",
          {mem_we, done, mem_be, mem_addr, mem_wdata[9:0]},
          {1'b1, 1'b0, q_be[0], q_addr[0], q_dat[0][9:0]});
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mem_ready = lfsr[3] | lfsr[7];
      @(posedge clk);
      if (mem_ready) begin
        void'(q_addr.pop_front());
        void'(q_be.pop_front());
        void'(q_dat.pop_front());
      end
      @(negedge clk);
      if (fails > 20) begin
        q_addr.delete(); q_be.delete(); q_dat.delete();
      end
    end
    mem_ready = 1'b0;
    chk(done && !busy && !mem_we && err_param == e_par && err_rop == e_rop,
        req, "completion", {done, busy, mem_we, err_param, err_rop},
        {1'b1, 1'b0, 1'b0, e_par, e_rop});
    @(negedge clk);
    chk(!done, "R5", "done single cycle", 80'(done), 80'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    chk(!busy && !done && !mem_we && !err_param && !err_rop, "R11", "reset state",
        {busy, done, mem_we, err_param, err_rop}, 80'(0));
    // R1 R2 R10: byte pixels, odd start lane, positive pitch
    run(32'h0000_0101, 8, 5, 3, 32'hA1B2_C3D4, 8'hF0, 0, 2'b11, "R1/R2");
    // R1 R2: half-word pixels, negative pitch
    run(32'h0000_0202, -12, 6, 2, 32'h1234_5678, 8'hF0, 1, 2'b00, "R1/R2 neg");
    // R3: colour only
    run(32'h0000_1000, 16, 8, 2, 32'hDEAD_BEEF, 8'hF0, 2, 2'b01, "R3 colour");
    // R3: alpha only
    run(32'h0000_2004, 12, 4, 3, 32'hCAFE_F00D, 8'hF0, 2, 2'b10, "R3 alpha");
    // R3 R4: both channels, longer run under stalls
    run(32'h0001_0000, 64, 24, 4, 32'h0BAD_F00D, 8'hF0, 2, 2'b11, "R3/R4 both");
    // R9: zero pitch single row
    run(32'h0000_3003, 0, 7, 1, 32'h0000_0055, 8'hF0, 0, 2'b00, "R9");
    // R6: misaligned base, pitch, width limit, width granularity, bad depth
    run(32'h0000_0201, 8, 4, 2, 32'h1, 8'hF0, 1, 2'b00, "R6 base");
    run(32'h0000_0200, 6, 4, 2, 32'h1, 8'hF0, 0, 2'b00, "R6 pitch");
    run(32'h0000_0200, 0, 32768, 1, 32'h1, 8'hF0, 0, 2'b00, "R6 width");
    run(32'h0000_0200, 8, 6, 1, 32'h1, 8'hF0, 2, 2'b11, "R6 granularity");
    run(32'h0000_0200, 8, 4, 1, 32'h1, 8'hF0, 3, 2'b11, "R6 depth");
    // R7: unsupported code, then keep-destination code
    run(32'h0000_0400, 8, 4, 2, 32'h1, 8'h33, 0, 2'b00, "R7 unsupported");
    run(32'h0000_0400, 8, 4, 2, 32'h1, 8'hAA, 0, 2'b00, "R7 keep");
    // R8: empty cases
    run(32'h0000_0400, 8, 4, 0, 32'h1, 8'hF0, 0, 2'b00, "R8 height");
    run(32'h0000_0400, 8, 0, 2, 32'h1, 8'hF0, 0, 2'b00, "R8 width");
    run(32'h0000_0400, 8, 8, 2, 32'h1, 8'hF0, 2, 2'b00, "R8 mask");
    // R12 R7: flags clear on next good command
    run(32'h0000_0500, 4, 4, 2, 32'h77, 8'hF0, 1, 2'b00, "R12/R7 clear");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule